// File: doc/BRIEF.md
# DMA Channel Event Interrupt Aggregator

This block gathers completion events from a set of DMA channels and turns them into a single interrupt request for software. Each channel raises single-cycle pulses for three kinds of progress: half of a transfer done, one descriptor done, and the whole descriptor chain done. Every channel owns a four-bit field inside a bank register, and each bank register holds eight channels. For each bank there is one mask register and one sticky pending register.

Software sets the mask bits for the events it wants to see. When an interrupt arrives it reads the pending registers and writes the same value back to acknowledge them. A summary register shows which channels have anything pending. The interrupt line is high while any pending bit is set. Access goes through a simple single-cycle request port. A read returns its data one cycle after the request.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset, every mask bit and pending bit is 0, `irq_o` is 0 and `rdata_o` is 0.
- R2: Event e of channel c (e: 0 half done, 1 descriptor done, 2 chain done; input bit `evt_i[3*c+e]`) lands in bank c/8 at bit 4*(c mod 8)+e. The mask of bank b sits at offset 4*b. The pending register of bank b sits at offset 0x10+4*b.
- R3: A pending bit becomes 1 only in the cycle after its event pulse, and only when its mask bit already held 1 in the cycle of the pulse.
- R4: A pending bit stays at 1 until it is cleared. Writing 0 to a pending bit, or writing to other offsets, leaves it unchanged.
- R5: Writing 1 to a pending bit clears it in the cycle after the write.
- R6: If an enabled event and a clearing write hit the same pending bit in the same cycle, the bit ends up at 1.
- R7: `irq_o` is 1 exactly when at least one pending bit in either bank is 1.
- R8: Bit 3 of every four-bit field reads as 0 in both mask and pending registers, whatever value is written.
- R9: Once both mask registers hold 0, no event pulse sets a pending bit. After the existing bits are cleared, `irq_o` stays at 0.
- R10: Mask registers read back the value last written to them, with bit 3 of each field forced to 0.
- R11: The register at offset 0x30 is read-only. Its bit c is 1 when channel c has any pending bit, and bits at or above the channel count read 0.
- R12: Reads of unmapped offsets return 0. Writes to unmapped offsets change no register.
- R13: `rdata_o` is loaded on the clock edge that accepts a read request and holds its value while no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 48 | Event pulses, bit 3*c+e for channel c, event e |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: 16 channels in two banks of eight, three events per channel and a 32-bit data path. With only 48 event inputs, every channel-and-event pair can be swept one at a time, both masked and unmasked. This covers both banks, every field position and the clear path for each bit, and the bench works out each expected bank and bit position from the channel number. The same small size also makes it cheap to run full-register patterns for the reserved bits, the summary register, unmapped offsets and the same-cycle collision of an event with a clear.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int EVT_HALF  = 0;
  localparam int EVT_DESC  = 1;
  localparam int EVT_CHAIN = 2;

  localparam int MASK_BASE = 'h00;
  localparam int PEND_BASE = 'h10;
  localparam int SUMM_OFFS = 'h30;
  localparam int REG_STEP  = 4;
endpackage

// File: rtl/dma_irq_bank.sv
module dma_irq_bank #(
  parameter int CH  = 8,
  parameter int EVT = 3,
  parameter int FW  = 4,
  parameter int DW  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CH*EVT-1:0] evt_i,
  input  logic              mask_we_i,
  input  logic              pend_we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     mask_o,
  output logic [DW-1:0]     pend_o
);
  localparam int USED = CH * FW;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  for (genvar c = 0; c < CH; c++) begin : g_ch
    for (genvar f = 0; f < FW; f++) begin : g_fld
      localparam int IDX = c * FW + f;
      if (f < EVT) begin : g_live
        logic mask_q, pend_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) mask_q <= 1'b0;
          else if (mask_we_i) mask_q <= wdata_i[IDX];
        end
        // set uses the mask held before this edge; set beats clear
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) pend_q <= 1'b0;
          else pend_q <= (pend_q & ~(pend_we_i & wdata_i[IDX]))
                       | (evt_i[c*EVT+f] & mask_q);
        end
        assign mask_o[IDX] = mask_q;
        assign pend_o[IDX] = pend_q;
      end else begin : g_rsvd
        assign mask_o[IDX] = 1'b0;
        assign pend_o[IDX] = 1'b0;
      end
    end
  end

  if (DW > USED) begin : g_pad
    assign mask_o[DW-1:USED] = '0;
    assign pend_o[DW-1:USED] = '0;
  end
endmodule

// File: rtl/dma_irq_regif.sv
module dma_irq_regif
  import dma_irq_pkg::*;
#(
  parameter int NB = 2,
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [NB*DW-1:0] mask_all_i,
  input  logic [NB*DW-1:0] pend_all_i,
  input  logic [DW-1:0]  summ_i,
  output logic [NB-1:0]  mask_we_o,
  output logic [NB-1:0]  pend_we_o,
  output logic [DW-1:0]  rdata_o
);
  logic [DW-1:0] rd_mux;
  logic          unused_wd;
  assign unused_wd = ^wdata_i;

  for (genvar b = 0; b < NB; b++) begin : g_dec
    assign mask_we_o[b] = req_i & we_i & (addr_i == AW'(MASK_BASE + REG_STEP*b));
    assign pend_we_o[b] = req_i & we_i & (addr_i == AW'(PEND_BASE + REG_STEP*b));
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == AW'(SUMM_OFFS)) rd_mux = summ_i;
    for (int b = 0; b < NB; b++) begin
      if (addr_i == AW'(MASK_BASE + REG_STEP*b)) rd_mux = mask_all_i[b*DW +: DW];
      if (addr_i == AW'(PEND_BASE + REG_STEP*b)) rd_mux = pend_all_i[b*DW +: DW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (req_i && !we_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg #(
  parameter int NUM_CH = 16,
  parameter int CH_PER_BANK = 8,
  parameter int NUM_EVT = 3,
  parameter int FIELD_W = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_CH*NUM_EVT-1:0] evt_i,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      irq_o
);
  localparam int NB = NUM_CH / CH_PER_BANK;
  localparam int BANK_EVT = CH_PER_BANK * NUM_EVT;

  logic [NB*DATA_W-1:0] mask_all, pend_all;
  logic [NB-1:0]        mask_we, pend_we;
  logic [DATA_W-1:0]    summ;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    dma_irq_bank #(
      .CH(CH_PER_BANK), .EVT(NUM_EVT), .FW(FIELD_W), .DW(DATA_W)
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt_i[b*BANK_EVT +: BANK_EVT]),
      .mask_we_i (mask_we[b]),
      .pend_we_i (pend_we[b]),
      .wdata_i   (wdata_i),
      .mask_o    (mask_all[b*DATA_W +: DATA_W]),
      .pend_o    (pend_all[b*DATA_W +: DATA_W])
    );
  end

  for (genvar c = 0; c < DATA_W; c++) begin : g_summ
    if (c < NUM_CH) begin : g_ch
      localparam int BASE = (c / CH_PER_BANK) * DATA_W + FIELD_W * (c % CH_PER_BANK);
      assign summ[c] = |pend_all[BASE +: FIELD_W];
    end else begin : g_zero
      assign summ[c] = 1'b0;
    end
  end

  dma_irq_regif #(.NB(NB), .DW(DATA_W), .AW(ADDR_W)) u_regif (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .mask_all_i (mask_all),
    .pend_all_i (pend_all),
    .summ_i     (summ),
    .mask_we_o  (mask_we),
    .pend_we_o  (pend_we),
    .rdata_o    (rdata_o)
  );

  assign irq_o = |pend_all;
endmodule

// File: rtl/dma_irq_agg_chk.sv
module dma_irq_agg_chk
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CH_PER_BANK = 8,
  parameter int NUM_EVT = 3,
  parameter int FIELD_W = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_CH*NUM_EVT-1:0] evt_i,
  input logic                      req_i,
  input logic                      we_i,
  input logic [ADDR_W-1:0]         addr_i,
  input logic [DATA_W-1:0]         wdata_i,
  input logic [(NUM_CH/CH_PER_BANK)*DATA_W-1:0] mask_all,
  input logic [(NUM_CH/CH_PER_BANK)*DATA_W-1:0] pend_all,
  input logic                      irq_o
);
  localparam int NB = NUM_CH / CH_PER_BANK;
  localparam int TW = NB * DATA_W;

  logic [TW-1:0] evt_map, clr_map;

  always_comb begin
    evt_map = '0;
    for (int c = 0; c < NUM_CH; c++)
      for (int e = 0; e < NUM_EVT; e++)
        evt_map[(c / CH_PER_BANK) * DATA_W + FIELD_W * (c % CH_PER_BANK) + e] = evt_i[c*NUM_EVT+e];
  end

  always_comb begin
    clr_map = '0;
    for (int b = 0; b < NB; b++)
      if (req_i && we_i && addr_i == ADDR_W'(PEND_BASE + REG_STEP*b))
        clr_map[b*DATA_W +: DATA_W] = wdata_i;
  end

  // R3: newly set bits had an event and a mask bit one cycle earlier
  p_set_needs_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_all & ~$past(pend_all) & ~($past(evt_map) & $past(mask_all))) == '0);

  // R4/R5: a bit can only fall after a clearing write of 1
  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pend_all) & ~pend_all & ~$past(clr_map)) == '0);

  // R6: an enabled event always leaves its bit set
  p_evt_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(evt_map & mask_all) & ~pend_all) == '0);

  p_irq_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend_all != '0));

  p_irq_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (pend_all == '0));

  // R9: with all masks zero, pending can only stay or fall
  p_masked_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mask_all) == '0) |-> ((pend_all & ~$past(pend_all)) == '0));
endmodule

bind dma_irq_agg dma_irq_agg_chk #(
  .NUM_CH(NUM_CH), .CH_PER_BANK(CH_PER_BANK), .NUM_EVT(NUM_EVT),
  .FIELD_W(FIELD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .evt_i    (evt_i),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .mask_all (mask_all),
  .pend_all (pend_all),
  .irq_o    (irq_o)
);

// File: tb/sim_dma_irq_agg.sv
`timescale 1ns/1ps
module sim_dma_irq_agg;
  localparam int NCH = 16;
  localparam int NEV = 3;
  localparam logic [31:0] LIVE = 32'h7777_7777;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [NCH*NEV-1:0] evt_i = '0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dma_irq_agg u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic pulse(input logic [NCH*NEV-1:0] v);
    @(negedge clk_i);
    evt_i = v;
    @(negedge clk_i);
    evt_i = '0;
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    #12 rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 irq", {31'b0, irq_o}, 32'd0);
    chk("R1 rdata", rdata_o, 32'd0);
    rd(8'h00, d); chk("R1 mask0", d, 32'd0);
    rd(8'h14, d); chk("R1 pend1", d, 32'd0);

    // R2/R3/R5/R7/R11 sweep over every channel and event
    for (int c = 0; c < NCH; c++) begin
      for (int e = 0; e < NEV; e++) begin
        automatic int bk = c / 8;
        automatic int bp = 4 * (c % 8) + e;
        automatic logic [31:0] one = 32'd1 << bp;
        automatic logic [7:0] ma = 8'(4 * bk);
        automatic logic [7:0] pa = 8'(16 + 4 * bk);
        automatic logic [7:0] oa = 8'(16 + 4 * (1 - bk));
        // masked: no effect
        wr(ma, LIVE & ~one);
        pulse(48'd1 << (c*NEV+e));
        rd(pa, d); chk("R3 masked event ignored", d, 32'd0);
        chk("R3 irq stays low", {31'b0, irq_o}, 32'd0);
        // enabled
        wr(ma, one);
        pulse(48'd1 << (c*NEV+e));
        rd(pa, d); chk("R2 pending position", d, one);
        rd(oa, d); chk("R2 other bank clear", d, 32'd0);
        chk("R7 irq high", {31'b0, irq_o}, 32'd1);
        rd(8'h30, d); chk("R11 summary bit", d, 32'd1 << c);
        wr(pa, ~one); rd(pa, d); chk("R4 zero write keeps bit", d, one);
        wr(pa, one); rd(pa, d); chk("R5 clear", d, 32'd0);
        chk("R7 irq low", {31'b0, irq_o}, 32'd0);
        wr(ma, 32'd0);
      end
    end

    // R8/R10
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); chk("R8 mask reserved", d, LIVE);
    wr(8'h04, 32'hA5A5_5A5A); rd(8'h04, d); chk("R10 mask readback", d, 32'hA5A5_5A5A & LIVE);
    wr(8'h04, 32'hFFFF_FFFF);
    pulse('1);
    rd(8'h10, d); chk("R8 pend reserved bank0", d, LIVE);
    rd(8'h14, d); chk("R8 pend reserved bank1", d, LIVE);
    rd(8'h30, d); chk("R11 all channels", d, 32'h0000_FFFF);
    wr(8'h30, 32'hFFFF_FFFF); rd(8'h10, d); chk("R11 summary write ignored", d, LIVE);

    // R12
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, d); chk("R12 unmapped read", d, 32'd0);
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h14, d); chk("R12 pend untouched", d, LIVE);
    rd(8'h00, d); chk("R12 mask untouched", d, LIVE);

    // R6: clear and event in the same cycle on bit 1 of channel 0
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = 8'h10; wdata_i = 32'h0000_0002; evt_i = 48'h2;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; evt_i = '0;
    rd(8'h10, d); chk("R6 event beats clear", d, LIVE);
    wr(8'h10, LIVE);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = 8'h10; wdata_i = 32'h0000_0001; evt_i = 48'h1;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; evt_i = '0;
    rd(8'h10, d); chk("R6 event on cleared bit", d, 32'h1);

    // R13
    rd(8'h14, d);
    repeat (3) @(negedge clk_i);
    chk("R13 rdata holds", rdata_o, d);
    wr(8'h00, 32'd0);
    chk("R13 hold across write", rdata_o, d);

    // R9
    wr(8'h04, 32'd0);
    wr(8'h10, LIVE); wr(8'h14, LIVE);
    chk("R9 irq low after clear", {31'b0, irq_o}, 32'd0);
    pulse('1); pulse('1);
    rd(8'h10, d); rd(8'h14, d2);
    chk("R9 no set bank0", d, 32'd0);
    chk("R9 no set bank1", d2, 32'd0);
    chk("R9 irq stays low", {31'b0, irq_o}, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule